// File: doc/BRIEF.md
# Supply Rail Window Comparator Conditioner

This block takes the outputs of two free-running threshold comparators that watch one supply rail. The upper comparator is called hi and the lower one is called lo. It turns them into two status bits that are clean and synchronous to the logic clock. Each raw comparator bit first crosses into the clock domain through a two-stage synchronizer. A configuration bit then chooses what the first status bit reports:

- the plain upper-comparator result, or
- an in-range flag that is true only while the rail sits between the two thresholds.

The second status bit always reports the lower comparator. When the in-range flag is low, that second bit tells whether the rail is too low or too high.

Both paths then pass through a persistence filter. A new level reaches the output only after it has stayed unchanged for a programmable number of clocks:

- a long window (64 µs) when filtering is enabled;
- a short window (16 µs) when it is disabled.

The window lengths in clocks are derived from the clock frequency parameter. The in-range flag is meaningful only when the upper threshold is set above the lower one.

Top module: `wf_window_filter`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, both `stat_a_o` and `stat_b_o` read 0.
- R2: `stat_b_o` settles to the lower comparator level regardless of `win_mode_i`.
- R3: With `win_mode_i` = 0, `stat_a_o` settles to the upper comparator level.
- R4: With `win_mode_i` = 1, `stat_a_o` settles to (lo AND NOT hi). Three cases follow from this:
  - lo=0, hi=0 gives 0 (below the range);
  - lo=1, hi=0 gives 1 (inside the range);
  - lo=1, hi=1 gives 0 (above the range).
- R5: With `filt_en_i` = 1, a comparator change that is held steady appears on the output on exactly the (LONG+2)-th rising edge after it is applied. LONG is CLK_MHZ×LONG_US, which is 512 by default.
- R6: With `filt_en_i` = 0, the same change appears on exactly the (SHORT+2)-th rising edge. SHORT is CLK_MHZ×SHORT_US, which is 128 by default.
- R7: A comparator pulse held for fewer clocks than the active window leaves the output unchanged. A pulse held for exactly the window length does pass.
- R8: A change of `win_mode_i` restarts the filter count of the A path. A change of `filt_en_i` restarts the count of both paths. On the edge where the change is first sampled the output holds its value. With steady comparators, a newly selected A level appears on the (N+1)-th edge, where N is the active window length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_hi_i | input | 1 | Raw asynchronous upper-comparator output |
| cmp_lo_i | input | 1 | Raw asynchronous lower-comparator output |
| win_mode_i | input | 1 | 0: A reports the upper comparator; 1: A reports the in-range flag |
| filt_en_i | input | 1 | 1: long filter window; 0: short window |
| stat_a_o | output | 1 | Filtered A status |
| stat_b_o | output | 1 | Filtered lower-comparator status |

## Verification
A comparator change applied between edges is counted through a fixed pipeline before it reaches the output:

- two synchronizer edges;
- then N edges of the persistence filter.

The new output level is therefore due on edge N+2. A configuration change reaches the mux combinationally but restarts the count, so its result is due on edge N+1. The directed checks sample on the falling edge one cycle before and exactly at these edges, so that both too-early and too-late updates are caught. The random phase holds every stimulus for more than the long window plus the pipeline, then compares against the settled value computed by a bench function.

// File: rtl/wf_pkg.sv
package wf_pkg;

    typedef enum logic {
        SEL_UPPER  = 1'b0,
        SEL_WINDOW = 1'b1
    } a_sel_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } cmp_pair_t;

    localparam int NUM_PATHS = 2;
    localparam int PATH_A    = 0;
    localparam int PATH_B    = 1;

    function automatic logic in_range(input cmp_pair_t p);
        return p.lo & ~p.hi;
    endfunction

    function automatic logic pick_a(input a_sel_e sel, input cmp_pair_t p);
        return (sel == SEL_WINDOW) ? in_range(p) : p.hi;
    endfunction

endpackage

// File: rtl/wf_sync.sv
module wf_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wf_persist.sv
module wf_persist #(
    parameter int LONG_CYC  = 512,
    parameter int SHORT_CYC = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    input  logic long_sel,
    input  logic restart,
    output logic q
);
    localparam int CW = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYC - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = long_sel ? LONG_LAST : SHORT_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= 1'b0;
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (d == q) begin
            cnt <= '0;
        end else if (cnt >= last) begin
            q   <= d;
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wf_window_filter.sv
module wf_window_filter
    import wf_pkg::*;
#(
    parameter int CLK_MHZ  = 8,
    parameter int LONG_US  = 64,
    parameter int SHORT_US = 16,
    parameter int SYNC_STG = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cmp_hi_i,
    input  logic cmp_lo_i,
    input  logic win_mode_i,
    input  logic filt_en_i,
    output logic stat_a_o,
    output logic stat_b_o
);
    localparam int LONG_CYC  = CLK_MHZ * LONG_US;
    localparam int SHORT_CYC = CLK_MHZ * SHORT_US;

    cmp_pair_t raw_pair, syn_pair;
    a_sel_e    a_sel;
    logic      win_q, fen_q;
    logic [NUM_PATHS-1:0] flt_in;
    logic [NUM_PATHS-1:0] flt_restart;
    logic [NUM_PATHS-1:0] flt_out;

    assign raw_pair = '{hi: cmp_hi_i, lo: cmp_lo_i};

    wf_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pair),
        .q   (syn_pair)
    );

    // configuration shadow, captured every cycle so changes are always seen
    always_ff @(posedge clk) begin
        win_q <= win_mode_i;
        fen_q <= filt_en_i;
    end

    assign a_sel = a_sel_e'(win_mode_i);

    assign flt_in[PATH_A]      = pick_a(a_sel, syn_pair);
    assign flt_in[PATH_B]      = syn_pair.lo;
    assign flt_restart[PATH_A] = (win_q != win_mode_i) | (fen_q != filt_en_i);
    assign flt_restart[PATH_B] = (fen_q != filt_en_i);

    for (genvar i = 0; i < NUM_PATHS; i++) begin : g_path
        wf_persist #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_flt (
            .clk      (clk),
            .rst      (rst),
            .d        (flt_in[i]),
            .long_sel (filt_en_i),
            .restart  (flt_restart[i]),
            .q        (flt_out[i])
        );
    end

    assign stat_a_o = flt_out[PATH_A];
    assign stat_b_o = flt_out[PATH_B];
endmodule

// File: rtl/wf_window_filter_chk.sv
module wf_window_filter_chk (
    input logic       clk,
    input logic       rst,
    input logic       win_mode_i,
    input logic       filt_en_i,
    input logic       stat_a_o,
    input logic       stat_b_o,
    input logic [1:0] flt_in
);
    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (stat_a_o == 1'b0 && stat_b_o == 1'b0));

    // R2: B only ever moves to the level its filter input held
    a_r2_b_follows_lo: assert property (@(posedge clk) disable iff (rst)
        !$stable(stat_b_o) |-> (stat_b_o == $past(flt_in[1])));

    // R3 / R4: A only ever moves to the selected level
    a_r3_a_follows_sel: assert property (@(posedge clk) disable iff (rst)
        !$stable(stat_a_o) |-> (stat_a_o == $past(flt_in[0])));

    // R8: a configuration change holds A on the restart edge
    a_r8_restart_holds_a: assert property (@(posedge clk) disable iff (rst)
        (!$stable(win_mode_i) || !$stable(filt_en_i)) |=> $stable(stat_a_o));

    // R8: an enable change holds B on the restart edge
    a_r8_restart_holds_b: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_en_i) |=> $stable(stat_b_o));
endmodule

bind wf_window_filter wf_window_filter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .win_mode_i (win_mode_i),
    .filt_en_i  (filt_en_i),
    .stat_a_o   (stat_a_o),
    .stat_b_o   (stat_b_o),
    .flt_in     (flt_in)
);

// File: tb/tb_wf_window_filter.sv
`timescale 1ns/1ps
module tb_wf_window_filter;
    localparam int LONG  = 8 * 64;
    localparam int SHORT = 8 * 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hi = 1'b0, lo = 1'b0, win = 1'b0, fen = 1'b1;
    logic sa, sb;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    always #2.5 clk = ~clk;

    wf_window_filter dut (
        .clk        (clk),
        .rst        (rst),
        .cmp_hi_i   (hi),
        .cmp_lo_i   (lo),
        .win_mode_i (win),
        .filt_en_i  (fen),
        .stat_a_o   (sa),
        .stat_b_o   (sb)
    );

    function automatic logic exp_a(logic h, logic l, logic w);
        return w ? (l & ~h) : h;
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle(logic h, logic l, logic w, logic f);
        hi = h; lo = l; win = w; fen = f;
        edges(LONG + 8);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit seen;
        void'($urandom(32'd1234));
        @(negedge clk);
        hi = 1'b1; lo = 1'b1;
        edges(3);
        check("R1 a in reset", sa, 1'b0);
        check("R1 b in reset", sb, 1'b0);
        rst = 1'b0;
        edges(1);
        check("R1 a after reset", sa, 1'b0);
        check("R1 b after reset", sb, 1'b0);

        // R5: long latency, fen=1, win=0
        settle(1'b0, 1'b0, 1'b0, 1'b1);
        hi = 1'b1; lo = 1'b1;
        edges(LONG + 1);
        check("R5 a not before LONG+2", sa, 1'b0);
        check("R5 b not before LONG+2", sb, 1'b0);
        edges(1);
        check("R5 R3 a at LONG+2", sa, 1'b1);
        check("R5 R2 b at LONG+2", sb, 1'b1);

        // R6: short latency
        settle(1'b1, 1'b1, 1'b0, 1'b0);
        hi = 1'b0;
        edges(SHORT + 1);
        check("R6 a not before SHORT+2", sa, 1'b1);
        edges(1);
        check("R6 a at SHORT+2", sa, 1'b0);

        // R7: glitch of SHORT-1 clocks is rejected
        seen = 0;
        hi = 1'b1;
        repeat (SHORT - 1) @(posedge clk);
        @(negedge clk);
        hi = 1'b0;
        for (int k = 0; k < 2 * SHORT; k++) begin
            @(negedge clk);
            if (sa) seen = 1;
        end
        check("R7 short glitch ignored", seen, 1'b0);
        // R7: pulse of exactly SHORT clocks passes
        seen = 0;
        hi = 1'b1;
        repeat (SHORT) @(posedge clk);
        @(negedge clk);
        hi = 1'b0;
        for (int k = 0; k < 2 * SHORT + 8; k++) begin
            @(negedge clk);
            if (sa) seen = 1;
        end
        check("R7 full-length pulse passes", seen, 1'b1);

        // R4: window truth table with B
        settle(1'b0, 1'b0, 1'b1, 1'b0);
        check("R4 below window a", sa, 1'b0);
        check("R2 below window b", sb, 1'b0);
        settle(1'b0, 1'b1, 1'b1, 1'b0);
        check("R4 inside window a", sa, 1'b1);
        check("R2 inside window b", sb, 1'b1);
        settle(1'b1, 1'b1, 1'b1, 1'b0);
        check("R4 above window a", sa, 1'b0);
        check("R2 above window b", sb, 1'b1);

        // R8: mode change restarts count, result due on edge N+1
        settle(1'b0, 1'b1, 1'b0, 1'b0);
        check("R8 a settled upper", sa, 1'b0);
        win = 1'b1;
        edges(SHORT);
        check("R8 a not before N+1", sa, 1'b0);
        edges(1);
        check("R8 a at N+1", sa, 1'b1);
        check("R8 b untouched by mode", sb, 1'b1);

        // random settled-state checks
        for (int it = 0; it < 30; it++) begin
            logic h, l, w, f;
            h = 1'($urandom); l = 1'($urandom);
            w = 1'($urandom); f = 1'($urandom);
            if (w && h && !l) l = 1'b1; // window needs upper above lower
            settle(h, l, w, f);
            check(w ? "R4 random a" : "R3 random a", sa, exp_a(h, l, w));
            check("R2 random b", sb, l);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule